// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retire

This block is the in-flight instruction window of an out-of-order core. Instructions are entered at dispatch, in program order, one per cycle. Each accepted instruction receives the number of the slot it occupies as its tag. Execution units later report results against that tag over a single result bus. The buffer retires instructions strictly in program order from its oldest slot. A retiring register-writing instruction drives a write port of the architectural register file. A retiring store is released to the memory system.

Before an instruction retires, the buffer also serves as a source of operands. Two lookup ports take an architectural register number. Each returns the youngest in-flight instruction that writes that register. If that instruction has already completed, the port also returns its result, so the consumer does not need to wait for the tag. When a branch that completed with a misprediction reaches the oldest slot, it retires and every younger entry is discarded in the same edge.

Top module: `retire_queue`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, `retire_valid` is 0 and no lookup port reports a hit.
- R2: `alloc_ready` is 0 exactly when all DEPTH slots are occupied (outside a flush cycle). An allocation request made while `alloc_ready` is 0 changes nothing.
- R3: `alloc_tag` is the slot the next accepted allocation takes. Accepted allocations receive consecutive tags modulo DEPTH. After a flush, numbering restarts at tag 0.
- R4: A completion stores `done_value` and `done_mispredict` into the slot named by `done_tag` and marks that slot done. A completion naming a slot that holds no instruction is ignored.
- R5: Retirement happens in program order and only when the oldest entry is done. In that cycle `retire_valid` is 1 and `retire_reg_idx`/`retire_value` show that entry's destination and result. The slot is freed at the next clock edge.
- R6: The kind of an instruction is taken from the allocation flags, and the branch flag wins over the store flag. When a register instruction retires, `retire_reg_we` is 1. When a store retires, `retire_store` is 1 and `retire_reg_we` is 0. When a branch retires, both are 0.
- R7: A lookup port reports a hit with the tag of the youngest occupied register-writing entry whose destination equals `src_reg`. Stores and branches never match. The result reflects the state at the start of the cycle: an allocation in the same cycle is not seen.
- R8: When the matching entry is done, `src_done` is 1 and `src_value` carries its result. Otherwise `src_done` is 0.
- R9: When the oldest entry is a done branch with its mispredict bit set, `retire_flush` and `retire_valid` are both 1. At the next edge every entry is discarded and the buffer is empty.
- R10: `alloc_ready` is 0 in a cycle in which `retire_flush` is 1.
- R11: An allocation and a retirement in the same cycle leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Dispatch requests a slot |
| alloc_dest | input | AREG_W | Destination architectural register |
| alloc_is_store | input | 1 | Instruction is a store |
| alloc_is_branch | input | 1 | Instruction is a branch (wins over store) |
| alloc_ready | output | 1 | A slot can be accepted this cycle |
| alloc_tag | output | IDX_W | Tag given to the allocation |
| done_valid | input | 1 | Result bus carries a completion |
| done_tag | input | IDX_W | Slot that completed |
| done_value | input | DATA_W | Result value |
| done_mispredict | input | 1 | Branch resolved against its prediction |
| src_reg | input | NUM_SRC x AREG_W | Register looked up per port |
| src_hit | output | NUM_SRC | An in-flight producer exists |
| src_done | output | NUM_SRC | That producer has completed |
| src_tag | output | NUM_SRC x IDX_W | Tag of the producer |
| src_value | output | NUM_SRC x DATA_W | Producer result when done |
| retire_valid | output | 1 | Oldest entry retires this cycle |
| retire_reg_we | output | 1 | Register file write enable |
| retire_reg_idx | output | AREG_W | Register file write index |
| retire_value | output | DATA_W | Register file write data |
| retire_store | output | 1 | Release the retiring store |
| retire_flush | output | 1 | Mispredicted branch retires; younger entries are discarded |

## Verification
The bench builds the block with its defaults: DEPTH=8, two lookup ports, 5-bit register numbers and 32-bit data. With only eight slots, the pointers wrap many times during the random phase. The full condition with simultaneous allocate and retire is reached within a few cycles of directed stimulus. Flushes can strike with the pointers at any position. A small pool of destination registers makes several in-flight producers of the same register common, which exercises the youngest-match selection on both lookup ports.

// File: rtl/retire_pkg.sv
// Shared definitions for the reorder buffer.
// Assumes: used only by the retire_* modules.
package retire_pkg;
    // Kind of an in-flight instruction, decided at allocation.
    typedef enum logic [1:0] {
        KIND_REG    = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_BRANCH = 2'd2
    } kind_e;
endpackage

// File: rtl/retire_ptrs.sv
// Head/tail/occupancy control of the circular buffer.
// Assumes: push is never asserted when full; pop only when occupied;
// flush wins over push and pop and returns both pointers to slot 0.
module retire_ptrs #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] occ,
    output logic             full
);
    logic [IDX_W-1:0] head_nx;
    logic [IDX_W-1:0] tail_nx;

    // Wrapping increments that also work for a depth that is not a power of two.
    assign head_nx = (head == IDX_W'(DEPTH - 1)) ? '0 : head + 1'b1;
    assign tail_nx = (tail == IDX_W'(DEPTH - 1)) ? '0 : tail + 1'b1;
    assign full    = (occ == CNT_W'(DEPTH));

    // Advance the pointers and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head <= '0;
            tail <= '0;
            occ  <= '0;
        end else begin
            if (push) tail <= tail_nx;
            if (pop)  head <= head_nx;
            case ({push, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end
endmodule

// File: rtl/retire_entries.sv
// Slot storage: per-slot occupied/done/mispredict bits, kind, destination
// and result. Assumes push targets a free slot and pop the head slot.
module retire_entries
    import retire_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 3,
    parameter int AREG_W = 5,
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [IDX_W-1:0]             tail,
    input  kind_e                        push_kind,
    input  logic [AREG_W-1:0]            push_dest,
    input  logic                         pop,
    input  logic [IDX_W-1:0]             head,
    input  logic                         flush,
    input  logic                         cmp_valid,
    input  logic [IDX_W-1:0]             cmp_tag,
    input  logic [DATA_W-1:0]            cmp_value,
    input  logic                         cmp_mis,
    output logic [DEPTH-1:0]             e_valid,
    output logic [DEPTH-1:0]             e_done,
    output logic [DEPTH-1:0]             e_mis,
    output kind_e [DEPTH-1:0]            e_kind,
    output logic [DEPTH-1:0][AREG_W-1:0] e_dest,
    output logic [DEPTH-1:0][DATA_W-1:0] e_value
);
    // Per-slot update: flush clears all; otherwise retire, complete, allocate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_valid <= '0;
            e_done  <= '0;
            e_mis   <= '0;
            e_kind  <= {DEPTH{KIND_REG}};
            e_dest  <= '0;
            e_value <= '0;
        end else if (flush) begin
            e_valid <= '0;
            e_done  <= '0;
            e_mis   <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (pop && head == IDX_W'(i)) begin
                    e_valid[i] <= 1'b0;
                    e_done[i]  <= 1'b0;
                end
                if (cmp_valid && cmp_tag == IDX_W'(i) && e_valid[i]) begin
                    e_value[i] <= cmp_value;
                    e_done[i]  <= 1'b1;
                    e_mis[i]   <= cmp_mis;
                end
                if (push && tail == IDX_W'(i)) begin
                    e_valid[i] <= 1'b1;
                    e_done[i]  <= 1'b0;
                    e_mis[i]   <= 1'b0;
                    e_kind[i]  <= push_kind;
                    e_dest[i]  <= push_dest;
                    e_value[i] <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/retire_lookup.sv
// One operand lookup port: finds the youngest occupied register-writing
// slot whose destination matches. Assumes occupied slots are contiguous
// from head, so walking from head visits them oldest to youngest.
module retire_lookup
    import retire_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 3,
    parameter int AREG_W = 5,
    parameter int DATA_W = 32
) (
    input  logic [IDX_W-1:0]             head,
    input  logic [DEPTH-1:0]             e_valid,
    input  logic [DEPTH-1:0]             e_done,
    input  kind_e [DEPTH-1:0]            e_kind,
    input  logic [DEPTH-1:0][AREG_W-1:0] e_dest,
    input  logic [DEPTH-1:0][DATA_W-1:0] e_value,
    input  logic [AREG_W-1:0]            src,
    output logic                         hit,
    output logic                         done,
    output logic [IDX_W-1:0]             tag,
    output logic [DATA_W-1:0]            value
);
    logic [IDX_W-1:0] pos;

    // Age-ordered walk; a younger match overrides an older one.
    always_comb begin
        hit = 1'b0;
        tag = '0;
        pos = '0;
        for (int k = 0; k < DEPTH; k++) begin
            pos = IDX_W'((int'(head) + k) % DEPTH);
            if (e_valid[pos] && e_kind[pos] == KIND_REG && e_dest[pos] == src) begin
                hit = 1'b1;
                tag = pos;
            end
        end
    end

    // Forward the producer's result once it has completed.
    always_comb begin
        done  = hit && e_done[tag];
        value = e_value[tag];
    end
endmodule

// File: rtl/retire_queue.sv
// Reorder buffer top: in-order allocation, tagged completion, operand
// lookup and in-order retirement with flush on a mispredicted branch.
// Assumes: at most one allocation, one completion and one retirement per
// cycle; DEPTH >= 2.
module retire_queue
    import retire_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int AREG_W  = 5,
    parameter int DATA_W  = 32,
    parameter int NUM_SRC = 2,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_valid,
    input  logic [AREG_W-1:0]             alloc_dest,
    input  logic                          alloc_is_store,
    input  logic                          alloc_is_branch,
    output logic                          alloc_ready,
    output logic [IDX_W-1:0]              alloc_tag,
    input  logic                          done_valid,
    input  logic [IDX_W-1:0]              done_tag,
    input  logic [DATA_W-1:0]             done_value,
    input  logic                          done_mispredict,
    input  logic [NUM_SRC-1:0][AREG_W-1:0] src_reg,
    output logic [NUM_SRC-1:0]            src_hit,
    output logic [NUM_SRC-1:0]            src_done,
    output logic [NUM_SRC-1:0][IDX_W-1:0] src_tag,
    output logic [NUM_SRC-1:0][DATA_W-1:0] src_value,
    output logic                          retire_valid,
    output logic                          retire_reg_we,
    output logic [AREG_W-1:0]             retire_reg_idx,
    output logic [DATA_W-1:0]             retire_value,
    output logic                          retire_store,
    output logic                          retire_flush
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [IDX_W-1:0]             head;
    logic [IDX_W-1:0]             tail;
    logic [CNT_W-1:0]             occ;
    logic                         full;
    logic                         push;
    kind_e                        alloc_kind;
    logic [DEPTH-1:0]             e_valid;
    logic [DEPTH-1:0]             e_done;
    logic [DEPTH-1:0]             e_mis;
    kind_e [DEPTH-1:0]            e_kind;
    logic [DEPTH-1:0][AREG_W-1:0] e_dest;
    logic [DEPTH-1:0][DATA_W-1:0] e_value;
    kind_e                        head_kind;

    // Kind decode: the branch flag takes precedence over the store flag.
    always_comb begin
        if (alloc_is_branch)     alloc_kind = KIND_BRANCH;
        else if (alloc_is_store) alloc_kind = KIND_STORE;
        else                     alloc_kind = KIND_REG;
    end

    // Retirement decision from the oldest slot.
    always_comb begin
        head_kind      = e_kind[head];
        retire_valid   = e_valid[head] && e_done[head];
        retire_flush   = retire_valid && head_kind == KIND_BRANCH && e_mis[head];
        retire_reg_we  = retire_valid && head_kind == KIND_REG;
        retire_store   = retire_valid && head_kind == KIND_STORE;
        retire_reg_idx = e_dest[head];
        retire_value   = e_value[head];
    end

    // Allocation handshake: refused when full or while flushing.
    always_comb begin
        alloc_ready = !full && !retire_flush;
        alloc_tag   = tail;
        push        = alloc_valid && alloc_ready;
    end

    retire_ptrs #(
        .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) ptrs_i (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(retire_valid),
        .flush(retire_flush), .head(head), .tail(tail), .occ(occ), .full(full)
    );

    retire_entries #(
        .DEPTH(DEPTH), .IDX_W(IDX_W), .AREG_W(AREG_W), .DATA_W(DATA_W)
    ) ents_i (
        .clk(clk), .rst_n(rst_n), .push(push), .tail(tail),
        .push_kind(alloc_kind), .push_dest(alloc_dest),
        .pop(retire_valid), .head(head), .flush(retire_flush),
        .cmp_valid(done_valid), .cmp_tag(done_tag), .cmp_value(done_value),
        .cmp_mis(done_mispredict),
        .e_valid(e_valid), .e_done(e_done), .e_mis(e_mis), .e_kind(e_kind),
        .e_dest(e_dest), .e_value(e_value)
    );

    for (genvar p = 0; p < NUM_SRC; p++) begin : g_src
        retire_lookup #(
            .DEPTH(DEPTH), .IDX_W(IDX_W), .AREG_W(AREG_W), .DATA_W(DATA_W)
        ) look_i (
            .head(head), .e_valid(e_valid), .e_done(e_done), .e_kind(e_kind),
            .e_dest(e_dest), .e_value(e_value), .src(src_reg[p]),
            .hit(src_hit[p]), .done(src_done[p]), .tag(src_tag[p]),
            .value(src_value[p])
        );
    end
endmodule

// File: rtl/retire_queue_chk.sv
// Property checker for retire_queue, attached by bind below.
// Assumes: occ is the top's occupancy count.
module retire_queue_chk #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic             alloc_ready,
    input logic [IDX_W-1:0] alloc_tag,
    input logic             retire_valid,
    input logic             retire_reg_we,
    input logic             retire_store,
    input logic             retire_flush,
    input logic [CNT_W-1:0] occ
);
    // R2
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CNT_W'(DEPTH)) |-> !alloc_ready);
    // R10
    flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire_flush |-> !alloc_ready);
    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire_flush |=> (occ == '0));
    // R5
    empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> !retire_valid);
    // R6
    kind_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({retire_reg_we, retire_store, retire_flush}));
    // R11
    occ_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready && retire_valid) |=> $stable(occ));
    // R3
    tag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready) |=>
        (alloc_tag == (($past(alloc_tag) == IDX_W'(DEPTH - 1)) ? '0 : $past(alloc_tag) + 1'b1)));
endmodule

bind retire_queue retire_queue_chk #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_tag(alloc_tag), .retire_valid(retire_valid), .retire_reg_we(retire_reg_we),
    .retire_store(retire_store), .retire_flush(retire_flush), .occ(occ)
);

// File: tb/retire_queue_tb_top.sv
// Bench: behavioural queue model, compared on every cycle.
module retire_queue_tb_top;
    localparam int CLK_NS = 10;
    localparam int DEPTH  = 8;
    localparam int AREG_W = 5;
    localparam int DATA_W = 32;
    localparam int NS     = 2;
    localparam int IW     = 3;

    typedef struct {
        int              tag;
        int              kind;   // 0 register, 1 store, 2 branch
        int              dest;
        logic [DATA_W-1:0] val;
        bit              done;
        bit              mis;
    } rec_t;

    logic clk = 1'b0;
    logic rst_n;
    logic alloc_valid, alloc_is_store, alloc_is_branch;
    logic [AREG_W-1:0] alloc_dest;
    logic alloc_ready;
    logic [IW-1:0] alloc_tag;
    logic done_valid, done_mispredict;
    logic [IW-1:0] done_tag;
    logic [DATA_W-1:0] done_value;
    logic [NS-1:0][AREG_W-1:0] src_reg;
    logic [NS-1:0] src_hit, src_done;
    logic [NS-1:0][IW-1:0] src_tag;
    logic [NS-1:0][DATA_W-1:0] src_value;
    logic retire_valid, retire_reg_we, retire_store, retire_flush;
    logic [AREG_W-1:0] retire_reg_idx;
    logic [DATA_W-1:0] retire_value;

    rec_t q[$];
    int ntag = 0;
    int total = 0;
    int bad = 0;

    always #(CLK_NS / 2) clk = ~clk;

    retire_queue #(.DEPTH(DEPTH), .AREG_W(AREG_W), .DATA_W(DATA_W), .NUM_SRC(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_dest(alloc_dest),
        .alloc_is_store(alloc_is_store), .alloc_is_branch(alloc_is_branch),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag), .done_valid(done_valid),
        .done_tag(done_tag), .done_value(done_value), .done_mispredict(done_mispredict),
        .src_reg(src_reg), .src_hit(src_hit), .src_done(src_done), .src_tag(src_tag),
        .src_value(src_value), .retire_valid(retire_valid), .retire_reg_we(retire_reg_we),
        .retire_reg_idx(retire_reg_idx), .retire_value(retire_value),
        .retire_store(retire_store), .retire_flush(retire_flush)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Compare all outputs with the model, then advance the model over one edge.
    task automatic tick();
        int sz;
        bit xr, xf, xa;
        #1;
        sz = q.size();
        xr = (sz > 0) && q[0].done;
        xf = xr && q[0].kind == 2 && q[0].mis;
        xa = (sz < DEPTH) && !xf;
        chk(alloc_ready == xa, xf ? "R10" : ((sz == DEPTH) ? "R2 R11" : "R2"), alloc_ready, xa);
        if (xa) chk(int'(alloc_tag) == ntag, "R3", alloc_tag, ntag);
        chk(retire_valid == xr, "R5", retire_valid, xr);
        chk(retire_reg_we == (xr && q[0].kind == 0), "R6", retire_reg_we, xr && q[0].kind == 0);
        chk(retire_store == (xr && q[0].kind == 1), "R6", retire_store, xr && q[0].kind == 1);
        chk(retire_flush == xf, "R9", retire_flush, xf);
        if (xr && q[0].kind == 0) begin
            chk(int'(retire_reg_idx) == q[0].dest, "R5", retire_reg_idx, q[0].dest);
            chk(retire_value == q[0].val, "R4", retire_value, q[0].val);
        end
        for (int p = 0; p < NS; p++) begin
            int j;
            j = -1;
            for (int k = sz - 1; k >= 0; k--)
                if (j < 0 && q[k].kind == 0 && q[k].dest == int'(src_reg[p])) j = k;
            chk(src_hit[p] == (j >= 0), "R7", src_hit[p], j >= 0);
            if (j >= 0) begin
                chk(int'(src_tag[p]) == q[j].tag, "R7", src_tag[p], q[j].tag);
                chk(src_done[p] == q[j].done, "R8", src_done[p], q[j].done);
                if (q[j].done) chk(src_value[p] == q[j].val, "R8", src_value[p], q[j].val);
            end
        end
        @(posedge clk);
        if (xf) begin
            q.delete();
            ntag = 0;
        end else begin
            if (done_valid)
                foreach (q[j]) if (q[j].tag == int'(done_tag)) begin
                    q[j].val  = done_value;
                    q[j].done = 1'b1;
                    q[j].mis  = done_mispredict;
                end
            if (xr) void'(q.pop_front());
            if (alloc_valid && xa) begin
                rec_t r;
                r.tag  = ntag;
                r.kind = alloc_is_branch ? 2 : (alloc_is_store ? 1 : 0);
                r.dest = int'(alloc_dest);
                r.val  = '0;
                r.done = 1'b0;
                r.mis  = 1'b0;
                q.push_back(r);
                ntag = (ntag + 1) % DEPTH;
            end
        end
        @(negedge clk);
    endtask

    task automatic cyc(input bit av, input int d, input bit st, input bit br,
                       input bit cv, input int ct, input int cval, input bit cm,
                       input int s0, input int s1);
        alloc_valid     = av;
        alloc_dest      = AREG_W'(d);
        alloc_is_store  = st;
        alloc_is_branch = br;
        done_valid      = cv;
        done_tag        = IW'(ct);
        done_value      = DATA_W'(cval);
        done_mispredict = cm;
        src_reg[0]      = AREG_W'(s0);
        src_reg[1]      = AREG_W'(s1);
        tick();
    endtask

    initial begin
        #(CLK_NS * 200000);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        alloc_valid = 0; alloc_dest = '0; alloc_is_store = 0; alloc_is_branch = 0;
        done_valid = 0; done_tag = '0; done_value = '0; done_mispredict = 0;
        src_reg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: empty after reset
        chk(alloc_ready == 1'b1, "R1", alloc_ready, 1);
        chk(alloc_tag == '0, "R1", alloc_tag, 0);
        chk(retire_valid == 1'b0, "R1", retire_valid, 0);
        chk(src_hit == '0, "R1", src_hit, 0);

        // R4: completion to an unallocated slot is ignored
        cyc(0, 0, 0, 0, 1, 2, 77, 0, 1, 2);
        // R2: fill all slots with repeated destinations, then one refused request
        for (int i = 0; i < DEPTH + 1; i++) cyc(1, i % 3 + 1, 0, 0, 0, 0, 0, 0, 1, 2);
        // R7/R8: complete a younger producer of register 1 first, then the oldest
        cyc(0, 0, 0, 0, 1, 3, 303, 0, 1, 2);
        cyc(0, 0, 0, 0, 1, 0, 100, 0, 1, 1);
        // R11: allocate while the head retires
        cyc(1, 4, 0, 0, 1, 1, 101, 0, 4, 2);
        cyc(1, 4, 0, 0, 0, 0, 0, 0, 4, 1);
        for (int i = 2; i < DEPTH; i++) cyc(0, 0, 0, 0, 1, i, 200 + i, 0, 1, 4);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, i, 500 + i, 0, 4, 2);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 4, 2);

        // R6: store, branch, store+branch flags, register
        cyc(1, 5, 1, 0, 0, 0, 0, 0, 5, 6);
        cyc(1, 6, 0, 1, 0, 0, 0, 0, 5, 6);
        cyc(1, 5, 1, 1, 0, 0, 0, 0, 5, 6);
        cyc(1, 6, 0, 0, 0, 0, 0, 0, 5, 6);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, (ntag + DEPTH - 4 + i) % DEPTH, 60 + i, 0, 5, 6);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 5, 6);

        // R9/R10: mispredicted branch behind a register op, younger entries discarded
        begin
            int b;
            b = ntag;
            cyc(1, 7, 0, 0, 0, 0, 0, 0, 7, 8);
            cyc(1, 0, 0, 1, 0, 0, 0, 0, 7, 8);
            cyc(1, 7, 0, 0, 0, 0, 0, 0, 7, 8);
            cyc(1, 8, 0, 0, 1, (b + 2) % DEPTH, 9, 0, 7, 8);
            cyc(0, 0, 0, 0, 1, (b + 1) % DEPTH, 0, 1, 7, 8);
            cyc(1, 3, 0, 0, 1, b, 11, 0, 7, 8);
            for (int i = 0; i < 4; i++) cyc(1, 3, 0, 0, 0, 0, 0, 0, 7, 3);
            for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, i, 40 + i, 0, 3, 7);
            for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 3, 7);
        end

        // Random traffic over all requirements
        for (int n = 0; n < 4000; n++) begin
            bit cv, cm;
            int ct;
            cv = 0; ct = 0;
            if (q.size() > 0 && ($urandom % 2) == 1) begin
                int j;
                j  = int'($urandom % q.size());
                ct = q[j].tag;
                cv = 1;
            end else if (($urandom % 6) == 0) begin
                ct = int'($urandom % DEPTH);
                cv = 1;
            end
            cm = (($urandom % 5) == 0);
            cyc(($urandom % 10) < 7, int'($urandom % 4), ($urandom % 5) == 0,
                ($urandom % 6) == 0, cv, ct, int'($urandom), cm,
                int'($urandom % 4), int'($urandom % 4));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule